// File: doc/BRIEF.md
# Host-to-Peripheral Command Mailbox

This block sits between a 32-bit host register bus and the 8-bit port bus of a small local controller. The host posts three kinds of 16-bit words: a command pointer, a legacy command word and a destination address. Each word is split into a low byte and a high byte, and the local controller reads the two bytes on fixed low port numbers. The local controller returns a 16-bit completion status through two byte ports, and the host reads it back as one word. A fixed result code is also readable by the host.

A local flag byte tells the controller's polling loop that a command is waiting. It also carries a constant "ready for host-memory DMA" bit and a bit that inverts on every read, which firmware uses as a liveness signal. The pending bit is held by a two-state machine. The states are `CMD_IDLE` and `CMD_PENDING`. The transition `post` (a host write to the command-pointer or legacy register) moves to or stays in `CMD_PENDING`. The transition `ack` (a local write to port 0x21 with no `post` in the same cycle) moves to `CMD_IDLE`. An interrupt-status port reports a constant bit together with the floppy-controller interrupt line.

Host reads are combinational from `host_addr`. Local reads are registered: `port_rdata` holds the value selected at the clock edge where `port_rd` was high, and keeps it until the next read.

Top module: `cmd_mailbox`

## Requirements
- R1: A host write at offset 0x20 or at its alias 0x21 loads the command pointer. Local port 0x02 returns `host_wdata[7:0]` and port 0x03 returns `host_wdata[15:8]`.
- R2: A host write at offset 0x24 loads the legacy command. Port 0x00 returns its bits [7:0] and port 0x01 returns its bits [15:8].
- R3: A host write at offset 0x28 loads the destination address. Port 0x06 returns its bits [7:0] and port 0x07 returns its bits [15:8].
- R4: A host write at 0x20, 0x21 or 0x24 clears the completion status and sets flag bit 1 (command pending). If a local status write happens in the same cycle, the clear wins. A write at 0x28 changes neither the status nor the flag.
- R5: Local writes to port 0x04 set status bits [7:0] and writes to port 0x05 set status bits [15:8]. A host read at offset 0x2C returns the 16-bit status zero-extended to 32 bits.
- R6: Any local write to port 0x21 clears flag bit 1. A host write of R4 in the same cycle keeps bit 1 set.
- R7: After reset the stored flag byte is 0x04 (bit 2 = ready for host-memory DMA), and all mailbox bytes and the status are 0.
- R8: Each local read of port 0x38 first inverts flag bit 5 and then returns the updated byte on `port_rdata` after that clock edge. Starting from reset, successive reads return 0x24, then 0x04.
- R9: A local read of port 0x39 returns 0x01 when `fdc_irq` is low and 0x09 when it is high.
- R10: A host read at offset 0x30 returns 0x00000010. Any host offset other than 0x2C and 0x30 reads 0.
- R11: Local reads of ports 0x04, 0x05 and any other undefined port return 0x00. Local writes to ports 0x00–0x03, 0x06 and 0x07 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 8 | Host register offset |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational from host_addr) |
| port_addr | input | 8 | Local port number |
| port_wr | input | 1 | Local write strobe |
| port_rd | input | 1 | Local read strobe |
| port_wdata | input | 8 | Local write data |
| port_rdata | output | 8 | Local read data, registered |
| fdc_irq | input | 1 | Floppy-controller interrupt line |

## Verification
The byte split is tried with distinct patterns on each of the three host words and on both command-pointer offsets. Using a different pattern per word exposes byte swaps, crossed port numbers and a dead alias. The pending bit is driven by posts alone, by acknowledges alone, and by both in the same cycle, which tells the two priority orders apart. Repeated flag reads separate an invert-then-return design from a return-then-invert design. Status writes are set against a destination write and against a same-cycle post, which shows which host writes clear the status.

// File: rtl/mb_pkg.sv
package mb_pkg;

    // Two-state machine that holds the command-pending bit.
    typedef enum logic {
        CMD_IDLE    = 1'b0,
        CMD_PENDING = 1'b1
    } cmd_state_e;

    // Local port numbers. Firmware decodes these, so they are fixed.
    localparam logic [7:0] P_LEG_LO  = 8'h00;
    localparam logic [7:0] P_LEG_HI  = 8'h01;
    localparam logic [7:0] P_PTR_LO  = 8'h02;
    localparam logic [7:0] P_PTR_HI  = 8'h03;
    localparam logic [7:0] P_STS_LO  = 8'h04;
    localparam logic [7:0] P_STS_HI  = 8'h05;
    localparam logic [7:0] P_DST_LO  = 8'h06;
    localparam logic [7:0] P_DST_HI  = 8'h07;
    localparam logic [7:0] P_ACK     = 8'h21;
    localparam logic [7:0] P_FLAG    = 8'h38;
    localparam logic [7:0] P_INTSTS  = 8'h39;

    // Flag byte bit positions.
    localparam int FLAG_PEND_BIT  = 1;
    localparam int FLAG_READY_BIT = 2;
    localparam int FLAG_LIVE_BIT  = 5;

    // Interrupt-status bit positions.
    localparam int INT_CONST_BIT = 0;
    localparam int INT_FDC_BIT   = 3;

    // Number of host-loaded 16-bit mailbox words.
    localparam int NUM_MBOX = 3;
    localparam int MB_PTR   = 0;
    localparam int MB_LEG   = 1;
    localparam int MB_DST   = 2;

endpackage

// File: rtl/mb_host_if.sv
module mb_host_if
    import mb_pkg::*;
#(
    parameter int          AW          = 8,
    parameter int          DW          = 32,
    parameter int          WW          = 16,
    parameter logic [7:0]  OFS_PTR_A   = 8'h20,
    parameter logic [7:0]  OFS_PTR_B   = 8'h21,
    parameter logic [7:0]  OFS_LEG     = 8'h24,
    parameter logic [7:0]  OFS_DST     = 8'h28,
    parameter logic [7:0]  OFS_STS     = 8'h2C,
    parameter logic [7:0]  OFS_RES     = 8'h30,
    parameter logic [31:0] RESULT_CODE = 32'h0000_0010
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] host_addr,
    input  logic          host_wr,
    input  logic [DW-1:0] host_wdata,
    input  logic [WW-1:0] status_word,
    output logic [WW-1:0] mbox_word [NUM_MBOX],
    output logic          post,
    output logic [DW-1:0] host_rdata
);

    localparam int PAD_W = DW - WW;

    logic [NUM_MBOX-1:0] hit;
    logic                unused_hi;

    assign unused_hi = ^host_wdata[DW-1:WW];

    always_comb begin
        hit         = '0;
        hit[MB_PTR] = (host_addr == AW'(OFS_PTR_A)) || (host_addr == AW'(OFS_PTR_B));
        hit[MB_LEG] = (host_addr == AW'(OFS_LEG));
        hit[MB_DST] = (host_addr == AW'(OFS_DST));
    end

    assign post = host_wr && (hit[MB_PTR] || hit[MB_LEG]);

    for (genvar k = 0; k < NUM_MBOX; k++) begin : g_mbox
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mbox_word[k] <= '0;
            end else if (host_wr && hit[k]) begin
                mbox_word[k] <= host_wdata[WW-1:0];
            end
        end
    end

    always_comb begin
        if (host_addr == AW'(OFS_STS)) begin
            host_rdata = {{PAD_W{1'b0}}, status_word};
        end else if (host_addr == AW'(OFS_RES)) begin
            host_rdata = DW'(RESULT_CODE);
        end else begin
            host_rdata = '0;
        end
    end

    // R1: a write at the alias offset loads the command pointer.
    a_r1_alias_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == AW'(OFS_PTR_B)) |=> mbox_word[MB_PTR] == $past(host_wdata[WW-1:0]));

    // R3: a destination write leaves the command pointer untouched.
    a_r3_dst_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == AW'(OFS_DST)) |=> $stable(mbox_word[MB_PTR]));

endmodule

// File: rtl/mb_flag_ctl.sv
module mb_flag_ctl
    import mb_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          post,
    input  logic          ack,
    input  logic          flag_rd,
    output logic [PW-1:0] flag_byte
);

    cmd_state_e state_q, state_d;
    logic       live_q;

    // Next-state logic: a post always wins over an ack in the same cycle.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CMD_IDLE: begin
                if (post) state_d = CMD_PENDING;
            end
            CMD_PENDING: begin
                if (ack && !post) state_d = CMD_IDLE;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CMD_IDLE;
            live_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (flag_rd) live_q <= ~live_q;
        end
    end

    // Output logic.
    always_comb begin
        flag_byte                 = '0;
        flag_byte[FLAG_READY_BIT] = 1'b1;
        flag_byte[FLAG_PEND_BIT]  = (state_q == CMD_PENDING);
        flag_byte[FLAG_LIVE_BIT]  = live_q;
    end

    // R4: a post sets the pending bit.
    a_r4_post_sets: assert property (@(posedge clk) disable iff (!rst_n)
        post |=> flag_byte[FLAG_PEND_BIT]);

    // R6: an ack with no post clears the pending bit.
    a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !post) |=> !flag_byte[FLAG_PEND_BIT]);

    // R8: every flag read inverts the liveness bit.
    a_r8_live_flips: assert property (@(posedge clk) disable iff (!rst_n)
        flag_rd |=> flag_byte[FLAG_LIVE_BIT] != $past(flag_byte[FLAG_LIVE_BIT]));

    // R6: with neither post nor ack, the pending bit holds.
    a_r6_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!post && !ack) |=> $stable(flag_byte[FLAG_PEND_BIT]));

endmodule

// File: rtl/mb_local_if.sv
module mb_local_if
    import mb_pkg::*;
#(
    parameter int PAW = 8,
    parameter int PW  = 8,
    parameter int WW  = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [PAW-1:0] port_addr,
    input  logic           port_wr,
    input  logic           port_rd,
    input  logic [PW-1:0]  port_wdata,
    input  logic [WW-1:0]  mbox_word [NUM_MBOX],
    input  logic [PW-1:0]  flag_byte,
    input  logic           fdc_irq,
    input  logic           status_clr,
    output logic [WW-1:0]  status_word,
    output logic           flag_rd,
    output logic           ack,
    output logic [PW-1:0]  port_rdata
);

    logic [PW-1:0] sts_lo_q, sts_hi_q;
    logic [PW-1:0] rd_next;
    logic [PW-1:0] live_mask;
    logic [PW-1:0] int_byte;

    assign flag_rd     = port_rd && (port_addr == PAW'(P_FLAG));
    assign ack         = port_wr && (port_addr == PAW'(P_ACK));
    assign status_word = {sts_hi_q, sts_lo_q};

    always_comb begin
        live_mask                = '0;
        live_mask[FLAG_LIVE_BIT] = 1'b1;
        int_byte                 = '0;
        int_byte[INT_CONST_BIT]  = 1'b1;
        int_byte[INT_FDC_BIT]    = fdc_irq;
    end

    // Completion status: a host post clears it ahead of any local write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_lo_q <= '0;
            sts_hi_q <= '0;
        end else if (status_clr) begin
            sts_lo_q <= '0;
            sts_hi_q <= '0;
        end else if (port_wr) begin
            if (port_addr == PAW'(P_STS_LO)) sts_lo_q <= port_wdata;
            if (port_addr == PAW'(P_STS_HI)) sts_hi_q <= port_wdata;
        end
    end

    always_comb begin
        case (port_addr)
            PAW'(P_LEG_LO): rd_next = mbox_word[MB_LEG][PW-1:0];
            PAW'(P_LEG_HI): rd_next = mbox_word[MB_LEG][WW-1:PW];
            PAW'(P_PTR_LO): rd_next = mbox_word[MB_PTR][PW-1:0];
            PAW'(P_PTR_HI): rd_next = mbox_word[MB_PTR][WW-1:PW];
            PAW'(P_DST_LO): rd_next = mbox_word[MB_DST][PW-1:0];
            PAW'(P_DST_HI): rd_next = mbox_word[MB_DST][WW-1:PW];
            PAW'(P_FLAG):   rd_next = flag_byte ^ live_mask;
            PAW'(P_INTSTS): rd_next = int_byte;
            default:        rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_rdata <= '0;
        end else if (port_rd) begin
            port_rdata <= rd_next;
        end
    end

    // R4: a post leaves the status at zero.
    a_r4_status_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        status_clr |=> status_word == '0);

    // R9: interrupt-status reads have bit 0 set and upper bits clear.
    a_r9_int_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (port_rd && port_addr == PAW'(P_INTSTS)) |=> (port_rdata[INT_CONST_BIT] && port_rdata[PW-1:4] == '0));

    // R11: the write-only status ports read back as zero.
    a_r11_sts_port_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (port_rd && (port_addr == PAW'(P_STS_LO) || port_addr == PAW'(P_STS_HI))) |=> port_rdata == '0);

    // R8: a flag read returns the ready bit set.
    a_r8_flag_ready: assert property (@(posedge clk) disable iff (!rst_n)
        flag_rd |=> port_rdata[FLAG_READY_BIT]);

endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
    import mb_pkg::*;
#(
    parameter int          HAW         = 8,
    parameter int          HDW         = 32,
    parameter int          PAW         = 8,
    parameter int          PW          = 8,
    parameter logic [31:0] RESULT_CODE = 32'h0000_0010
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [HAW-1:0]  host_addr,
    input  logic            host_wr,
    input  logic [HDW-1:0]  host_wdata,
    output logic [HDW-1:0]  host_rdata,
    input  logic [PAW-1:0]  port_addr,
    input  logic            port_wr,
    input  logic            port_rd,
    input  logic [PW-1:0]   port_wdata,
    output logic [PW-1:0]   port_rdata,
    input  logic            fdc_irq
);

    localparam int WW = 2 * PW;

    logic [WW-1:0] mbox_word [NUM_MBOX];
    logic [WW-1:0] status_word;
    logic [PW-1:0] flag_byte;
    logic          post;
    logic          ack;
    logic          flag_rd;

    mb_host_if #(
        .AW          (HAW),
        .DW          (HDW),
        .WW          (WW),
        .RESULT_CODE (RESULT_CODE)
    ) u_host (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_addr   (host_addr),
        .host_wr     (host_wr),
        .host_wdata  (host_wdata),
        .status_word (status_word),
        .mbox_word   (mbox_word),
        .post        (post),
        .host_rdata  (host_rdata)
    );

    mb_flag_ctl #(
        .PW (PW)
    ) u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .post      (post),
        .ack       (ack),
        .flag_rd   (flag_rd),
        .flag_byte (flag_byte)
    );

    mb_local_if #(
        .PAW (PAW),
        .PW  (PW),
        .WW  (WW)
    ) u_local (
        .clk         (clk),
        .rst_n       (rst_n),
        .port_addr   (port_addr),
        .port_wr     (port_wr),
        .port_rd     (port_rd),
        .port_wdata  (port_wdata),
        .mbox_word   (mbox_word),
        .flag_byte   (flag_byte),
        .fdc_irq     (fdc_irq),
        .status_clr  (post),
        .status_word (status_word),
        .flag_rd     (flag_rd),
        .ack         (ack),
        .port_rdata  (port_rdata)
    );

    // R6: a post together with an ack leaves a command pending.
    a_r6_post_beats_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (post && ack) |=> flag_byte[FLAG_PEND_BIT]);

endmodule

// File: tb/cmd_mailbox_tb.sv
module cmd_mailbox_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [7:0]  port_addr = '0;
    logic        port_wr = 1'b0;
    logic        port_rd = 1'b0;
    logic [7:0]  port_wdata = '0;
    logic [7:0]  port_rdata;
    logic        fdc_irq = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    cmd_mailbox u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .port_addr  (port_addr),
        .port_wr    (port_wr),
        .port_rd    (port_rd),
        .port_wdata (port_wdata),
        .port_rdata (port_rdata),
        .fdc_irq    (fdc_irq)
    );

    // op: 0 host write, 1 local read check, 2 local write, 3 host read check
    // layout: {op[1:0], req[3:0], addr[7:0], data[31:0], exp[31:0]}
    localparam int NV = 23;
    typedef logic [77:0] vec_t;
    localparam vec_t VEC [NV] = '{
        {2'd0, 4'd1,  8'h20, 32'h0000_A55A, 32'h0},          // R1 pointer, primary offset
        {2'd1, 4'd1,  8'h02, 32'h0,         32'h5A},
        {2'd1, 4'd1,  8'h03, 32'h0,         32'hA5},
        {2'd0, 4'd1,  8'h21, 32'hFFFF_1234, 32'h0},          // R1 alias offset
        {2'd1, 4'd1,  8'h02, 32'h0,         32'h34},
        {2'd1, 4'd1,  8'h03, 32'h0,         32'h12},
        {2'd0, 4'd2,  8'h24, 32'h0000_BEEF, 32'h0},          // R2 legacy
        {2'd1, 4'd2,  8'h00, 32'h0,         32'hEF},
        {2'd1, 4'd2,  8'h01, 32'h0,         32'hBE},
        {2'd0, 4'd3,  8'h28, 32'h0000_C0DE, 32'h0},          // R3 destination
        {2'd1, 4'd3,  8'h06, 32'h0,         32'hDE},
        {2'd1, 4'd3,  8'h07, 32'h0,         32'hC0},
        {2'd2, 4'd5,  8'h04, 32'h77,        32'h0},          // R5 status bytes
        {2'd2, 4'd5,  8'h05, 32'h99,        32'h0},
        {2'd3, 4'd5,  8'h2C, 32'h0,         32'h0000_9977},
        {2'd3, 4'd10, 8'h30, 32'h0,         32'h0000_0010},  // R10 result code
        {2'd3, 4'd10, 8'h34, 32'h0,         32'h0},          // R10 unmapped offset
        {2'd1, 4'd11, 8'h05, 32'h0,         32'h0},          // R11 status port reads 0
        {2'd2, 4'd11, 8'h02, 32'hFF,        32'h0},          // R11 write to read-only port
        {2'd1, 4'd11, 8'h02, 32'h0,         32'h34},
        {2'd0, 4'd4,  8'h24, 32'h0000_0102, 32'h0},          // R4 post clears status
        {2'd3, 4'd4,  8'h2C, 32'h0,         32'h0},
        {2'd1, 4'd11, 8'h10, 32'h0,         32'h0}           // R11 undefined port
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic hwr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hrd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic lwr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        port_addr = a; port_wdata = d; port_wr = 1'b1;
        @(negedge clk);
        port_wr = 1'b0;
    endtask

    task automatic lrd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        port_addr = a; port_rd = 1'b1;
        @(negedge clk);
        port_rd = 1'b0;
        d = port_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [31:0] w;

        do_reset();

        // R7: reset state of mailbox bytes and status
        lrd(8'h00, b);   chk("R7 legacy low after reset", {24'h0, b}, 32'h0);
        hrd(8'h2C, w);   chk("R7 status after reset", w, 32'h0);
        // R7 / R8: stored flag 0x04, first read inverts bit 5 first
        lrd(8'h38, b);   chk("R7 R8 first flag read", {24'h0, b}, 32'h24);
        lrd(8'h38, b);   chk("R8 second flag read", {24'h0, b}, 32'h04);

        // Table-driven main function
        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic [3:0]  rq;
            logic [7:0]  ad;
            logic [31:0] dt, ex;
            string       tag;
            {op, rq, ad, dt, ex} = VEC[i];
            tag = $sformatf("R%0d vector %0d", rq, i);
            case (op)
                2'd0: hwr(ad, dt);
                2'd1: begin lrd(ad, b); chk(tag, {24'h0, b}, ex); end
                2'd2: lwr(ad, dt[7:0]);
                default: begin hrd(ad, w); chk(tag, w, ex); end
            endcase
        end

        // R4: commands were posted, so pending is set (live bit was 0)
        lrd(8'h38, b);   chk("R4 pending after post", {24'h0, b}, 32'h26);
        // R6: ack on port 0x21 clears pending
        lwr(8'h21, 8'hAB);
        lrd(8'h38, b);   chk("R6 ack clears pending", {24'h0, b}, 32'h04);

        // R6: post and ack in the same cycle, post wins
        @(negedge clk);
        host_addr = 8'h24; host_wdata = 32'h0000_0505; host_wr = 1'b1;
        port_addr = 8'h21; port_wdata = 8'h00; port_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; port_wr = 1'b0;
        lrd(8'h38, b);   chk("R6 post beats ack", {24'h0, b}, 32'h26);

        // R4: destination write does not clear the status
        lwr(8'h04, 8'h11);
        hwr(8'h28, 32'h0000_3333);
        hrd(8'h2C, w);   chk("R4 dest write keeps status", w, 32'h0000_0011);
        lrd(8'h06, b);   chk("R3 dest low byte", {24'h0, b}, 32'h33);
        // R4: destination write does not touch the pending bit (stays set)
        lrd(8'h38, b);   chk("R4 dest write keeps flag", {24'h0, b}, 32'h06);

        // R4: post and local status write in the same cycle, clear wins
        @(negedge clk);
        host_addr = 8'h20; host_wdata = 32'h0000_4444; host_wr = 1'b1;
        port_addr = 8'h04; port_wdata = 8'h55; port_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; port_wr = 1'b0;
        hrd(8'h2C, w);   chk("R4 clear beats status write", w, 32'h0);

        // R9: interrupt-status port
        fdc_irq = 1'b0;
        lrd(8'h39, b);   chk("R9 irq low", {24'h0, b}, 32'h01);
        fdc_irq = 1'b1;
        lrd(8'h39, b);   chk("R9 irq high", {24'h0, b}, 32'h09);
        fdc_irq = 1'b0;

        // R11: write to legacy port is ignored
        lwr(8'h00, 8'h99);
        lrd(8'h00, b);   chk("R11 legacy port write ignored", {24'h0, b}, 32'h05);

        // R7: reset in mid-run restores everything
        do_reset();
        lrd(8'h02, b);   chk("R7 pointer low after reset", {24'h0, b}, 32'h0);
        hrd(8'h2C, w);   chk("R7 status after second reset", w, 32'h0);
        lrd(8'h38, b);   chk("R7 flag after second reset", {24'h0, b}, 32'h24);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule